// File: doc/BRIEF.md
# Cache-Line Outstanding Request Tracker

This block sits between one core's memory pipeline and its first-level cache controller. It records every request that is in flight, at cache-line granularity, and decides in the cycle a request is presented whether it may issue. A request can be refused for lack of room, or because it collides with earlier work on the same line. Load-type requests go into a read table and store-type requests go into a write table. A line held by an unfinished locked read-modify-write sequence turns away every other access to that line.

Completions name a line and the table it belongs to, and they free the matching entry. A completion that finds no entry flags a protocol error. A periodic watchdog compares the age of every entry with a threshold and raises a sticky deadlock flag. Four saturating counters record the kinds of aliasing that occur between load-type and store-type requests. Data movement, the coherence protocol and the cache arrays are outside this block.

Top module: `line_req_tracker`

## Requirements
- R1: `req_type_i` encodings. Code 0 (load) and code 1 (instruction fetch) use the read table. Codes 2 to 9 use the write table: 2 store, 3 RMW read, 4 RMW write, 5 load-linked, 6 store-conditional, 7 locked RMW read, 8 locked RMW write, 9 flush. Codes 10 to 15 are reserved and are treated as write-table requests.
- R2: A valid request gets status FULL (code 1) and is not inserted in two cases: the outstanding count is at or above `MAX_OUT`, or the request's own table has no free entry.
- R3: A request is refused with status ALIASED (code 2) when the other table holds an entry for the same line.
- R4: A request is refused with status ALIASED when its own table already holds an entry for the same line.
- R5: Completing a write-table entry of type 7 locks that line. Completing a write-table entry of type 8 releases the lock. While the lock is held, every request to the locked line except type 8 is refused with status ALIASED.
- R6: The refusal checks are applied in this order: FULL, then lock, then other-table alias, then own-table alias. A request that passes all of them gets status ISSUED (code 0), `req_accept_o` goes high in the same cycle, and the request is inserted at the clock edge.
- R7: The four alias counters each saturate at all ones. They count write-table requests refused for a read-table entry, write-table requests refused for a write-table entry, read-table requests refused for a read-table entry, and read-table requests refused for a write-table entry. Refusals for FULL or for the lock are not counted.
- R8: A completion removes the entry for its line from the table that `cpl_is_wr_i` selects. If no such entry exists, `cpl_err_o` is high in that cycle and no state changes.
- R9: `outstanding_o` always equals the number of valid read-table entries plus the number of valid write-table entries.
- R10: A check timer starts on an accepted request when the timer is idle and fires every `DL_THRESH` cycles. When it fires it sets `deadlock_o` if any entry's age has reached `DL_THRESH`. It re-arms while requests remain outstanding. `deadlock_o` stays set until reset.
- R11: After reset both tables are empty, the lock is clear, every counter is zero, and `deadlock_o` is low.
- R12: The low log2(`LINE_BYTES`) address bits are ignored for all matching, on both the request port and the completion port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A request is presented this cycle |
| req_addr_i | input | ADDR_W | Request byte address |
| req_type_i | input | 4 | Request type code (R1) |
| req_accept_o | output | 1 | Request issued this cycle |
| req_status_o | output | 2 | 0 issued, 1 full, 2 aliased |
| cpl_valid_i | input | 1 | A completion is presented this cycle |
| cpl_addr_i | input | ADDR_W | Completed line address |
| cpl_is_wr_i | input | 1 | 1 selects the write table, 0 the read table |
| cpl_err_o | output | 1 | Completion matched no entry |
| outstanding_o | output | OUT_W | Number of requests in flight |
| cnt_st_ld_o | output | STAT_W | Write-table requests refused for a read-table entry |
| cnt_st_st_o | output | STAT_W | Write-table requests refused for a write-table entry |
| cnt_ld_ld_o | output | STAT_W | Read-table requests refused for a read-table entry |
| cnt_ld_st_o | output | STAT_W | Read-table requests refused for a write-table entry |
| deadlock_o | output | 1 | Sticky deadlock flag |

## Verification
The assertions check the following on every cycle:
- no line is held in both tables at once;
- no tag appears twice within one table;
- the running count matches the table occupancy and stays within its bound;
- a locked line never admits a request other than the lock release;
- an unmatched completion leaves the count unchanged;
- the deadlock flag rises only on a timer firing and never falls.

The refusal priority, the exact status codes and the increments of the four alias counters need the bench's reference model. It checks them against mixed random traffic on a small pool of lines. The timing of the deadlock flag, including the re-arm after a request completes before the first firing, is shown only by directed scenarios.

// File: rtl/lrt_pkg.sv
package lrt_pkg;
  typedef enum logic [3:0] {
    RK_LOAD    = 4'd0,
    RK_IFETCH  = 4'd1,
    RK_STORE   = 4'd2,
    RK_RMW_RD  = 4'd3,
    RK_RMW_WR  = 4'd4,
    RK_LL      = 4'd5,
    RK_SC      = 4'd6,
    RK_LRMW_RD = 4'd7,
    RK_LRMW_WR = 4'd8,
    RK_FLUSH   = 4'd9
  } req_kind_e;

  typedef enum logic [1:0] {
    ST_ISSUED = 2'd0,
    ST_FULL   = 2'd1,
    ST_ALIAS  = 2'd2
  } req_stat_e;

  // R1: everything except load and ifetch goes to the write table
  function automatic logic is_write_kind(input logic [3:0] k);
    return k >= 4'd2;
  endfunction
endpackage

// File: rtl/line_table.sv
module line_table #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  parameter int TS_W   = 12,
  parameter int THRESH = 1000,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] look_line_i,
  output logic              look_hit_o,
  output logic              full_o,
  output logic [CNT_W-1:0]  used_o,
  input  logic              ins_i,
  input  logic [ADDR_W-1:0] ins_line_i,
  input  logic [3:0]        ins_kind_i,
  input  logic [TS_W-1:0]   ins_ts_i,
  input  logic              del_req_i,
  input  logic [ADDR_W-1:0] del_line_i,
  output logic              del_hit_o,
  output logic [3:0]        del_kind_o,
  input  logic [TS_W-1:0]   now_i,
  output logic              aged_o
);
  logic [DEPTH-1:0]              vld_q;
  logic [DEPTH-1:0][ADDR_W-1:0]  line_q;
  logic [DEPTH-1:0][3:0]         kind_q;
  logic [DEPTH-1:0][TS_W-1:0]    ts_q;
  logic [DEPTH-1:0]              look_m, del_m, old_m;
  logic [IDX_W-1:0]              free_idx;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    logic [TS_W-1:0] age;
    assign age       = now_i - ts_q[g];
    assign look_m[g] = vld_q[g] && (line_q[g] == look_line_i);
    assign del_m[g]  = vld_q[g] && (line_q[g] == del_line_i);
    assign old_m[g]  = vld_q[g] && (age >= TS_W'(THRESH));
  end

  assign look_hit_o = |look_m;
  assign del_hit_o  = del_req_i && (|del_m);
  assign aged_o     = |old_m;
  assign full_o     = &vld_q;

  always_comb begin
    free_idx   = '0;
    del_kind_o = '0;
    used_o     = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld_q[i]) free_idx = IDX_W'(i);
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (del_m[i]) del_kind_o = kind_q[i];
      used_o = used_o + CNT_W'(vld_q[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      line_q <= '0;
      kind_q <= '0;
      ts_q   <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (del_req_i && del_m[i]) vld_q[i] <= 1'b0;
        if (ins_i && (free_idx == IDX_W'(i))) begin
          vld_q[i]  <= 1'b1;
          line_q[i] <= ins_line_i;
          kind_q[i] <= ins_kind_i;
          ts_q[i]   <= ins_ts_i;
        end
      end
    end
  end

  a_r2_no_insert_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_i |-> !full_o);
  a_r4_unique_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(look_m) <= 1);
  a_r8_single_delete: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(del_m));
endmodule

// File: rtl/dl_watch.sv
module dl_watch #(
  parameter int THRESH = 1000,
  parameter int TS_W   = 12,
  localparam int TMR_W = $clog2(THRESH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            busy_i,
  input  logic            aged_i,
  output logic [TS_W-1:0] now_o,
  output logic            deadlock_o
);
  logic [TS_W-1:0]  now_q;
  logic [TMR_W-1:0] tmr_q;
  logic             arm_q, dl_q, fire;

  assign fire       = arm_q && (tmr_q == TMR_W'(THRESH - 1));
  assign now_o      = now_q;
  assign deadlock_o = dl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      now_q <= '0;
      tmr_q <= '0;
      arm_q <= 1'b0;
      dl_q  <= 1'b0;
    end else begin
      now_q <= now_q + 1'b1;
      if (fire) begin
        tmr_q <= '0;
        arm_q <= busy_i;
        if (aged_i) dl_q <= 1'b1;
      end else if (arm_q) begin
        tmr_q <= tmr_q + 1'b1;
      end else if (start_i) begin
        tmr_q <= '0;
        arm_q <= 1'b1;
      end
    end
  end

  a_r10_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dl_q |=> dl_q);
  a_r10_flag_on_check: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dl_q) |-> $past(fire));
endmodule

// File: rtl/alias_stats.sv
module alias_stats #(
  parameter int NUM    = 4,
  parameter int STAT_W = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM-1:0]              inc_i,
  output logic [NUM-1:0][STAT_W-1:0]  cnt_o
);
  for (genvar g = 0; g < NUM; g++) begin : g_cnt
    logic [STAT_W-1:0] c_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  c_q <= '0;
      else if (inc_i[g] && ~&c_q)   c_q <= c_q + 1'b1;
    end
    assign cnt_o[g] = c_q;

    a_r7_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (&c_q) |=> (&c_q));
  end
endmodule

// File: rtl/line_req_tracker.sv
module line_req_tracker
  import lrt_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int RD_DEPTH   = 4,
  parameter int WR_DEPTH   = 4,
  parameter int MAX_OUT    = 6,
  parameter int DL_THRESH  = 1000,
  parameter int STAT_W     = 8,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int OUT_W     = $clog2(RD_DEPTH + WR_DEPTH + 1),
  localparam int TS_W      = $clog2(DL_THRESH) + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [3:0]        req_type_i,
  output logic              req_accept_o,
  output logic [1:0]        req_status_o,
  input  logic              cpl_valid_i,
  input  logic [ADDR_W-1:0] cpl_addr_i,
  input  logic              cpl_is_wr_i,
  output logic              cpl_err_o,
  output logic [OUT_W-1:0]  outstanding_o,
  output logic [STAT_W-1:0] cnt_st_ld_o,
  output logic [STAT_W-1:0] cnt_st_st_o,
  output logic [STAT_W-1:0] cnt_ld_ld_o,
  output logic [STAT_W-1:0] cnt_ld_st_o,
  output logic              deadlock_o
);
  localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'(LINE_BYTES - 1);
  localparam int RD_CW = $clog2(RD_DEPTH + 1);
  localparam int WR_CW = $clog2(WR_DEPTH + 1);

  logic [ADDR_W-1:0] req_line, cpl_line;
  logic              wr_kind, rd_hit, wr_hit, rd_full, wr_full;
  logic              rd_aged, wr_aged, rd_del_hit, wr_del_hit;
  logic [3:0]        rd_del_kind, wr_del_kind, cpl_kind;
  logic [RD_CW-1:0]  rd_used;
  logic [WR_CW-1:0]  wr_used;
  logic [TS_W-1:0]   now;
  logic              full_c, lock_c, cross_c, same_c, accept, cpl_hit;
  req_stat_e         status;
  logic [OUT_W-1:0]  out_q;
  logic              lock_vld_q;
  logic [ADDR_W-1:0] lock_line_q;
  logic [3:0]        alias_inc;
  logic [3:0][STAT_W-1:0] alias_cnt;

  // R12: line granularity
  assign req_line = req_addr_i & LINE_MASK;
  assign cpl_line = cpl_addr_i & LINE_MASK;
  assign wr_kind  = is_write_kind(req_type_i);

  line_table #(.DEPTH(RD_DEPTH), .ADDR_W(ADDR_W), .TS_W(TS_W), .THRESH(DL_THRESH)) u_rd_tbl (
    .clk_i, .rst_ni,
    .look_line_i(req_line), .look_hit_o(rd_hit), .full_o(rd_full), .used_o(rd_used),
    .ins_i(accept && !wr_kind), .ins_line_i(req_line), .ins_kind_i(req_type_i), .ins_ts_i(now),
    .del_req_i(cpl_valid_i && !cpl_is_wr_i), .del_line_i(cpl_line),
    .del_hit_o(rd_del_hit), .del_kind_o(rd_del_kind),
    .now_i(now), .aged_o(rd_aged)
  );

  line_table #(.DEPTH(WR_DEPTH), .ADDR_W(ADDR_W), .TS_W(TS_W), .THRESH(DL_THRESH)) u_wr_tbl (
    .clk_i, .rst_ni,
    .look_line_i(req_line), .look_hit_o(wr_hit), .full_o(wr_full), .used_o(wr_used),
    .ins_i(accept && wr_kind), .ins_line_i(req_line), .ins_kind_i(req_type_i), .ins_ts_i(now),
    .del_req_i(cpl_valid_i && cpl_is_wr_i), .del_line_i(cpl_line),
    .del_hit_o(wr_del_hit), .del_kind_o(wr_del_kind),
    .now_i(now), .aged_o(wr_aged)
  );

  // R2..R6: refusal priority full > lock > cross alias > own alias
  always_comb begin
    full_c  = (out_q >= OUT_W'(MAX_OUT)) || (wr_kind ? wr_full : rd_full);
    lock_c  = lock_vld_q && (lock_line_q == req_line) && (req_type_i != RK_LRMW_WR);
    cross_c = wr_kind ? rd_hit : wr_hit;
    same_c  = wr_kind ? wr_hit : rd_hit;
    if (full_c)                           status = ST_FULL;
    else if (lock_c || cross_c || same_c) status = ST_ALIAS;
    else                                  status = ST_ISSUED;
  end

  assign accept       = req_valid_i && (status == ST_ISSUED);
  assign req_accept_o = accept;
  assign req_status_o = req_valid_i ? status : ST_ISSUED;

  // R7: alias events, counted only past the full and lock checks
  always_comb begin
    logic counted;
    counted      = req_valid_i && !full_c && !lock_c;
    alias_inc[0] = counted &&  wr_kind && rd_hit;
    alias_inc[1] = counted &&  wr_kind && !rd_hit && wr_hit;
    alias_inc[2] = counted && !wr_kind && !wr_hit && rd_hit;
    alias_inc[3] = counted && !wr_kind && wr_hit;
  end

  alias_stats #(.NUM(4), .STAT_W(STAT_W)) u_stats (
    .clk_i, .rst_ni, .inc_i(alias_inc), .cnt_o(alias_cnt)
  );
  assign cnt_st_ld_o = alias_cnt[0];
  assign cnt_st_st_o = alias_cnt[1];
  assign cnt_ld_ld_o = alias_cnt[2];
  assign cnt_ld_st_o = alias_cnt[3];

  // R8: completion
  assign cpl_hit   = cpl_is_wr_i ? wr_del_hit : rd_del_hit;
  assign cpl_kind  = cpl_is_wr_i ? wr_del_kind : rd_del_kind;
  assign cpl_err_o = cpl_valid_i && !cpl_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q       <= '0;
      lock_vld_q  <= 1'b0;
      lock_line_q <= '0;
    end else begin
      out_q <= out_q + OUT_W'(accept) - OUT_W'(cpl_hit);
      if (cpl_hit && cpl_is_wr_i) begin
        if (cpl_kind == RK_LRMW_RD) begin
          lock_vld_q  <= 1'b1;
          lock_line_q <= cpl_line;
        end else if (cpl_kind == RK_LRMW_WR) begin
          lock_vld_q  <= 1'b0;
        end
      end
    end
  end
  assign outstanding_o = out_q;

  dl_watch #(.THRESH(DL_THRESH), .TS_W(TS_W)) u_watch (
    .clk_i, .rst_ni,
    .start_i(accept),
    .busy_i((out_q != '0) || accept),
    .aged_i(rd_aged || wr_aged),
    .now_o(now),
    .deadlock_o(deadlock_o)
  );

  a_r9_count_matches_tables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_q == (OUT_W'(rd_used) + OUT_W'(wr_used)));
  a_r2_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_q <= OUT_W'(MAX_OUT));
  a_r3_tables_disjoint: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_hit && wr_hit));
  a_r5_lock_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && lock_vld_q && (lock_line_q == req_line) && (req_type_i != RK_LRMW_WR))
      |-> !req_accept_o);
  a_r8_bad_cpl_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpl_err_o && !req_accept_o) |=> $stable(out_q));
endmodule

// File: tb/line_req_tracker_bench.sv
module line_req_tracker_bench;
  localparam int AW = 32, MAXO = 6, DEP = 4, TH = 40, SW = 8;

  logic clk = 0, rst_ni = 0;
  logic req_valid, cpl_valid, cpl_is_wr;
  logic [AW-1:0] req_addr, cpl_addr;
  logic [3:0] req_type;
  logic req_accept, cpl_err, deadlock;
  logic [1:0] req_status;
  logic [3:0] outstanding;
  logic [SW-1:0] c_sl, c_ss, c_ll, c_ls;

  int n_chk = 0, n_fail = 0, cyc = 0;

  line_req_tracker #(.ADDR_W(AW), .LINE_BYTES(64), .RD_DEPTH(DEP), .WR_DEPTH(DEP),
    .MAX_OUT(MAXO), .DL_THRESH(TH), .STAT_W(SW)) u_line_req_tracker (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_type_i(req_type), .req_accept_o(req_accept), .req_status_o(req_status),
    .cpl_valid_i(cpl_valid), .cpl_addr_i(cpl_addr), .cpl_is_wr_i(cpl_is_wr),
    .cpl_err_o(cpl_err), .outstanding_o(outstanding), .cnt_st_ld_o(c_sl),
    .cnt_st_st_o(c_ss), .cnt_ld_ld_o(c_ll), .cnt_ld_st_o(c_ls), .deadlock_o(deadlock));

  always #4 clk = ~clk;

  // reference model
  bit  m_v[2][DEP];
  int  m_t[2][DEP];
  int  m_k[2][DEP];
  bit  m_lock;
  int  m_lock_t;
  int  m_cnt[4];
  int  m_out;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", rq, act, exp, cyc);
    end
  endtask

  function automatic int find(input int tb, input int tag);
    for (int i = 0; i < DEP; i++) if (m_v[tb][i] && m_t[tb][i] == tag) return i;
    return -1;
  endfunction

  function automatic int used(input int tb);
    int u = 0;
    for (int i = 0; i < DEP; i++) u += int'(m_v[tb][i]);
    return u;
  endfunction

  task automatic model_clear();
    for (int t = 0; t < 2; t++) for (int i = 0; i < DEP; i++) m_v[t][i] = 0;
    m_lock = 0; m_out = 0;
    for (int i = 0; i < 4; i++) m_cnt[i] = 0;
  endtask

  task automatic do_reset();
    req_valid = 0; cpl_valid = 0; req_addr = '0; cpl_addr = '0; req_type = '0; cpl_is_wr = 0;
    rst_ni = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1;
    model_clear();
  endtask

  // one cycle: drive, check against model, clock, update model
  task automatic step(input bit rv, input int rtag, input int roff, input int rt,
                      input bit cv, input int ctag, input bit cw);
    int tag, wr, rh, wh, st, ci;
    bit full, lk;
    @(negedge clk);
    req_valid = rv; req_addr = AW'((rtag << 6) | (roff & 63)); req_type = 4'(rt);
    cpl_valid = cv; cpl_addr = AW'((ctag << 6) | 5); cpl_is_wr = cw;
    #1;
    tag = rtag; wr = (rt >= 2) ? 1 : 0;
    rh = find(0, tag); wh = find(1, tag);
    full = (m_out >= MAXO) || (used(wr) == DEP);
    lk = m_lock && m_lock_t == tag && rt != 8;
    if (full) st = 1;
    else if (lk || rh >= 0 || wh >= 0) st = 2;
    else st = 0;
    if (rv) chk(req_status == 2'(st), "R1 R2 R3 R4 R5 R6 status", int'(req_status), st);
    chk(req_accept == (rv && st == 0), "R6 accept", int'(req_accept), int'(rv && st == 0));
    ci = cv ? find(cw, ctag) : -1;
    chk(cpl_err == (cv && ci < 0), "R8 cpl_err", int'(cpl_err), int'(cv && ci < 0));
    chk(int'(outstanding) == m_out, "R9 outstanding", int'(outstanding), m_out);
    chk(int'(c_sl) == m_cnt[0] && int'(c_ss) == m_cnt[1] &&
        int'(c_ll) == m_cnt[2] && int'(c_ls) == m_cnt[3], "R7 counters",
        int'({c_sl, c_ss, c_ll, c_ls}), (m_cnt[0] << 24) | (m_cnt[1] << 16) | (m_cnt[2] << 8) | m_cnt[3]);
    @(posedge clk);
    cyc++;
    if (rv && !full && !lk) begin
      if (wr == 1 && rh >= 0)                m_cnt[0] = (m_cnt[0] < 255) ? m_cnt[0] + 1 : 255;
      if (wr == 1 && rh < 0 && wh >= 0)      m_cnt[1] = (m_cnt[1] < 255) ? m_cnt[1] + 1 : 255;
      if (wr == 0 && wh < 0 && rh >= 0)      m_cnt[2] = (m_cnt[2] < 255) ? m_cnt[2] + 1 : 255;
      if (wr == 0 && wh >= 0)                m_cnt[3] = (m_cnt[3] < 255) ? m_cnt[3] + 1 : 255;
    end
    if (ci >= 0) begin
      m_v[cw][ci] = 0; m_out--;
      if (cw && m_k[1][ci] == 7) begin m_lock = 1; m_lock_t = ctag; end
      else if (cw && m_k[1][ci] == 8) m_lock = 0;
    end
    if (rv && st == 0) begin
      for (int i = 0; i < DEP; i++) if (!m_v[wr][i]) begin
        m_v[wr][i] = 1; m_t[wr][i] = tag; m_k[wr][i] = rt; break;
      end
      m_out++;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // R11: reset state
    #1;
    chk(outstanding == 0, "R11 outstanding", int'(outstanding), 0);
    chk(deadlock == 0, "R11 deadlock", int'(deadlock), 0);
    chk(req_accept == 0 && cpl_err == 0, "R11 idle outputs", int'({req_accept, cpl_err}), 0);
    chk({c_sl, c_ss, c_ll, c_ls} == '0, "R11 counters", int'({c_sl, c_ss, c_ll, c_ls}), 0);

    // R5: locked RMW sequence
    step(1, 'h10, 0, 7, 0, 0, 0);      // locked RMW read issued
    step(0, 0, 0, 0, 1, 'h10, 1);      // completes -> lock
    step(1, 'h10, 8, 0, 0, 0, 0);      // load refused by lock
    step(1, 'h10, 0, 2, 0, 0, 0);      // store refused by lock
    step(1, 'h11, 0, 0, 0, 0, 0);      // other line unaffected
    #2 chk(outstanding == 1, "R5 other line issued", int'(outstanding), 1);
    chk(c_ll == 0 && c_ls == 0 && c_ss == 0, "R7 lock refusals not counted", int'(c_ll), 0);
    step(1, 'h10, 0, 8, 0, 0, 0);      // locked RMW write passes
    step(0, 0, 0, 0, 1, 'h10, 1);      // completes -> unlock
    step(1, 'h10, 0, 0, 0, 0, 0);      // load now issues
    #2 chk(outstanding == 2, "R5 unlocked line issues", int'(outstanding), 2);

    // R12: offset bits ignored
    step(1, 'h10, 63, 1, 0, 0, 0);     // same line, other offset -> alias
    #2 chk(c_ll == 1, "R12 offset ignored for alias", int'(c_ll), 1);

    // R2: read table full before the count limit
    do_reset();
    for (int i = 0; i < 4; i++) step(1, 'h20 + i, 0, 0, 0, 0, 0);
    step(1, 'h30, 0, 1, 0, 0, 0);
    #2 chk(outstanding == 4, "R2 table full refusal", int'(outstanding), 4);
    step(1, 'h31, 0, 2, 0, 0, 0);
    step(1, 'h32, 0, 9, 0, 0, 0);
    step(1, 'h33, 0, 2, 0, 0, 0);      // count limit
    step(1, 'h20, 0, 2, 0, 0, 0);      // full wins over alias (R6)
    #2 chk(outstanding == MAXO && c_sl == 0, "R6 full before alias", int'(outstanding), MAXO);
    step(0, 0, 0, 0, 1, 'h77, 0);      // bogus completion
    #2 chk(outstanding == MAXO, "R8 bad completion no change", int'(outstanding), MAXO);

    // R10: deadlock after exactly the threshold
    do_reset();
    step(1, 'h40, 0, 0, 0, 0, 0);
    idle(TH - 1);
    #2 chk(deadlock == 0, "R10 no flag before check", int'(deadlock), 0);
    idle(1);
    #2 chk(deadlock == 1, "R10 flag at check", int'(deadlock), 1);
    idle(3);
    #2 chk(deadlock == 1, "R10 flag sticky", int'(deadlock), 1);

    // R10: re-arm, younger entry caught on second check
    do_reset();
    step(1, 'h41, 0, 2, 0, 0, 0);
    idle(9);
    step(0, 0, 0, 0, 1, 'h41, 1);
    idle(9);
    step(1, 'h42, 0, 0, 0, 0, 0);
    idle(20);
    #2 chk(deadlock == 0, "R10 young entry not flagged", int'(deadlock), 0);
    idle(35);
    #2 chk(deadlock == 0, "R10 before re-armed check", int'(deadlock), 0);
    idle(5);
    #2 chk(deadlock == 1, "R10 re-armed check flags", int'(deadlock), 1);

    // random mix: R1 R3 R4 R7 R8 R9
    do_reset();
    for (int n = 0; n < 3000; n++) begin
      int rtag, rt, ctag, tb, st0;
      bit cv, rv;
      rv = ($urandom % 4) != 0;
      rtag = 'h100 + int'($urandom % 6);
      rt = int'($urandom % 10);
      cv = ($urandom % 3) != 0;
      tb = int'($urandom % 2);
      ctag = 'h1ff;
      st0 = int'($urandom % DEP);
      if (($urandom % 5) != 0)
        for (int k = 0; k < DEP; k++)
          if (m_v[tb][(st0 + k) % DEP]) begin ctag = m_t[tb][(st0 + k) % DEP]; break; end
      step(rv, rtag, int'($urandom % 64), rt, cv, ctag, tb[0]);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule